// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Status

This block holds two 8-bit interval timers and the interrupt and status logic they share, in the form a classic FM sound generator presents them to its host. A byte-wide host port has two locations. A write to the index location picks an internal register. A write to the data location loads the register that the index picks. The status byte is always visible on `status`, which is what the host sees when it reads the index location. Reading it has no side effects.

The host programs a timer by loading its preload register with 256 minus the wanted tick count and then setting the timer's start bit. The counter counts up from the preload, one count per tick. When it steps past 0xFF it marks an expiry, reloads the preload and keeps counting. Both timers take their ticks from one free-running prescaler. The fast timer ticks once per base period, which is CYC_PER_TICK clocks and stands for 80 us. The slow timer ticks once every SLOW_RATIO base periods, which stands for 320 us. An expiry of an unmasked timer sets a flag that stays set until the host clears it. The interrupt output is the OR of the two flags.

Top module: `fmtmr_unit`

## Requirements
- R1: After reset, status reads 0x06 (both flags and the summary bit clear), irq is low, and both timers are stopped and unmasked.
- R2: A write with host_port=0 stores host_wdata as the register index. A write with host_port=1 goes to the register that index picks: 0x02 loads the fast-timer preload, 0x03 loads the slow-timer preload, 0x04 writes control. A data write to any other index changes nothing.
- R3: Control bit 0 starts the fast timer and bit 1 starts the slow timer. When a start bit goes from 0 to 1, that counter loads its preload. A timer whose start bit is 0 holds its count and never expires.
- R4: A started fast timer advances once every CYC_PER_TICK clocks. A started slow timer advances once every SLOW_RATIO×CYC_PER_TICK clocks. Stepping past 0xFF is an expiry and reloads the preload, so a preload P gives a period of 256−P ticks.
- R5: A fast-timer preload of 0xFF expires on the first base tick after the start, within CYC_PER_TICK clocks.
- R6: An expiry sets status bit 6 (fast timer) or bit 5 (slow timer) unless that timer is masked. Control bit 6 masks the fast timer and control bit 5 masks the slow timer. A masked expiry sets nothing.
- R7: Status bit 7 is set whenever bit 6 or bit 5 is set, and irq always equals status bit 7.
- R8: A control write with bit 7 set clears status bits 7..5. It leaves the start bits, the mask bits and the counters as they were.
- R9: Status bits 4..0 always read the SIGNATURE parameter (default 0x06).
- R10: A set flag stays set when its timer is stopped or masked later, and only a control write with bit 7 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_port | input | 1 | 0 selects the index location, 1 selects the data location |
| host_wdata | input | 8 | Host write byte |
| status | output | 8 | Status byte: summary flag, fast flag, slow flag, signature |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench checks expiry timing at both ends of the window one tick wide. A counter that started at the wrong value, or took the slow tick for the fast one, would raise its flag early or late by a whole tick period. It checks that masking holds back the flag but not the counting, and that an interrupt-reset write keeps the timer running. A design that let the reset write also clear the start bits would never raise the flag again. It also checks that a flag stays set after its timer is stopped or masked, and that a data write to an unused index starts nothing. A design that dropped the flag on stop, or decoded the index loosely, would show the wrong status byte.

// File: rtl/fmtmr_pkg.sv
package fmtmr_pkg;
  localparam int unsigned NUM_TMR = 2;
  localparam int unsigned BYTE_W  = 8;

  // register indices selected through the index location
  localparam logic [7:0] IDX_PRE_FAST = 8'h02;
  localparam logic [7:0] IDX_PRE_SLOW = 8'h03;
  localparam logic [7:0] IDX_CTRL     = 8'h04;

  // control byte fields
  localparam int unsigned CB_CLEAR     = 7;
  localparam int unsigned CB_MASK_FAST = 6;
  localparam int unsigned CB_MASK_SLOW = 5;
  localparam int unsigned CB_RUN_SLOW  = 1;
  localparam int unsigned CB_RUN_FAST  = 0;

  // status byte fields
  localparam int unsigned SB_SUMMARY = 7;
  localparam int unsigned SB_FAST    = 6;
  localparam int unsigned SB_SLOW    = 5;
  localparam int unsigned SIG_W      = 5;
endpackage

// File: rtl/fmtmr_prescale.sv
module fmtmr_prescale #(
  parameter int unsigned CYC_PER_TICK = 20000,
  parameter int unsigned SLOW_RATIO   = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_fast,
  output logic tick_slow
);
  localparam int unsigned DIV_W = (CYC_PER_TICK > 2) ? $clog2(CYC_PER_TICK) : 1;
  localparam int unsigned RAT_W = (SLOW_RATIO > 2) ? $clog2(SLOW_RATIO) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_PER_TICK - 1);
  localparam logic [RAT_W-1:0] RAT_LAST = RAT_W'(SLOW_RATIO - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [RAT_W-1:0] rat_q, rat_d;

  always_comb begin
    tick_fast = (div_q == DIV_LAST);
    tick_slow = tick_fast && (rat_q == RAT_LAST);
    div_d     = tick_fast ? '0 : div_q + 1'b1;
    rat_d     = rat_q;
    if (tick_fast) begin
      rat_d = (rat_q == RAT_LAST) ? '0 : rat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      rat_q <= '0;
    end else begin
      div_q <= div_d;
      rat_q <= rat_d;
    end
  end
endmodule

// File: rtl/fmtmr_regfile.sv
module fmtmr_regfile
  import fmtmr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_wr,
  input  logic                       host_port,
  input  logic [BYTE_W-1:0]          host_wdata,
  output logic [NUM_TMR-1:0][BYTE_W-1:0] preload,
  output logic [NUM_TMR-1:0]         run,
  output logic [NUM_TMR-1:0]         mask,
  output logic [NUM_TMR-1:0]         load,
  output logic                       clear
);
  logic [BYTE_W-1:0]              idx_q, idx_d;
  logic [NUM_TMR-1:0][BYTE_W-1:0] pre_q, pre_d;
  logic [NUM_TMR-1:0]             run_q, run_d;
  logic [NUM_TMR-1:0]             msk_q, msk_d;
  logic                           data_wr, ctl_wr, ctl_upd;
  logic [NUM_TMR-1:0]             run_new, msk_new;

  always_comb begin
    data_wr = host_wr && host_port;
    ctl_wr  = data_wr && (idx_q == IDX_CTRL);
    clear   = ctl_wr && host_wdata[CB_CLEAR];
    ctl_upd = ctl_wr && !host_wdata[CB_CLEAR];
    run_new = {host_wdata[CB_RUN_SLOW], host_wdata[CB_RUN_FAST]};
    msk_new = {host_wdata[CB_MASK_SLOW], host_wdata[CB_MASK_FAST]};
    load    = ctl_upd ? (run_new & ~run_q) : '0;

    idx_d = idx_q;
    pre_d = pre_q;
    run_d = run_q;
    msk_d = msk_q;
    if (host_wr && !host_port) begin
      idx_d = host_wdata;
    end
    if (data_wr && (idx_q == IDX_PRE_FAST)) begin
      pre_d[0] = host_wdata;
    end
    if (data_wr && (idx_q == IDX_PRE_SLOW)) begin
      pre_d[1] = host_wdata;
    end
    if (ctl_upd) begin
      run_d = run_new;
      msk_d = msk_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pre_q <= '0;
      run_q <= '0;
      msk_q <= '0;
    end else begin
      idx_q <= idx_d;
      pre_q <= pre_d;
      run_q <= run_d;
      msk_q <= msk_d;
    end
  end

  assign preload = pre_q;
  assign run     = run_q;
  assign mask    = msk_q;
endmodule

// File: rtl/fmtmr_counter.sv
module fmtmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] preload,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step, wrap;

  always_comb begin
    step   = run && tick;
    wrap   = step && (cnt_q == CNT_TOP);
    expire = wrap && !load;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = preload;
    end else if (step) begin
      cnt_d = wrap ? preload : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fmtmr_unit.sv
module fmtmr_unit
  import fmtmr_pkg::*;
#(
  parameter int unsigned CYC_PER_TICK = 20000,
  parameter int unsigned SLOW_RATIO   = 4,
  parameter logic [4:0]  SIGNATURE    = 5'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_port,
  input  logic [7:0] host_wdata,
  output logic [7:0] status,
  output logic       irq
);
  logic [1:0]                     sync_q;
  logic                           rst_sync_n;
  logic                           tick_fast, tick_slow;
  logic [NUM_TMR-1:0]             tick_sel;
  logic [NUM_TMR-1:0][BYTE_W-1:0] preload;
  logic [NUM_TMR-1:0]             run, mask, load, expire;
  logic                           clear;
  logic [NUM_TMR-1:0]             flag_q, flag_d;

  // reset asserts at once, deasserts two clocks after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = sync_q[1];

  fmtmr_prescale #(
    .CYC_PER_TICK(CYC_PER_TICK),
    .SLOW_RATIO  (SLOW_RATIO)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_fast(tick_fast),
    .tick_slow(tick_slow)
  );

  fmtmr_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .host_wr   (host_wr),
    .host_port (host_port),
    .host_wdata(host_wdata),
    .preload   (preload),
    .run       (run),
    .mask      (mask),
    .load      (load),
    .clear     (clear)
  );

  assign tick_sel = {tick_slow, tick_fast};

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    fmtmr_counter #(.CNT_W(BYTE_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tick   (tick_sel[t]),
      .run    (run[t]),
      .load   (load[t]),
      .preload(preload[t]),
      .expire (expire[t])
    );
  end

  always_comb begin
    flag_d = (flag_q & ~{NUM_TMR{clear}}) | (expire & ~mask);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    status               = '0;
    status[SB_SUMMARY]   = |flag_q;
    status[SB_FAST]      = flag_q[0];
    status[SB_SLOW]      = flag_q[1];
    status[SIG_W-1:0]    = SIGNATURE;
    irq                  = status[SB_SUMMARY];
  end
endmodule

// File: rtl/fmtmr_unit_chk.sv
module fmtmr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       irq,
  input logic       tick_fast,
  input logic       tick_slow,
  input logic [1:0] run,
  input logic [1:0] mask,
  input logic [1:0] expire,
  input logic [1:0] flag,
  input logic       clear
);
  p_irq_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == status[7]);

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> $past(|expire));

  p_slow_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |-> tick_fast);

  p_stop_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run[0] |-> !expire[0]);

  p_stop_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run[1] |-> !expire[1]);

  p_mask_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[0] && !flag[0]) |=> !flag[0]);

  p_mask_slow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[1] && !flag[1]) |=> !flag[1]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !clear) |=> flag[0]);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && expire == 2'b00) |=> status[7:5] == 3'b000);

  p_clear_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> $stable(run) && $stable(mask));
endmodule

bind fmtmr_unit fmtmr_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .status   (status),
  .irq      (irq),
  .tick_fast(tick_fast),
  .tick_slow(tick_slow),
  .run      (run),
  .mask     (mask),
  .expire   (expire),
  .flag     (flag_q),
  .clear    (clear)
);

// File: tb/fmtmr_unit_test.sv
`timescale 1ns/1ps
module fmtmr_unit_test;
  localparam int CPT   = 8;
  localparam int RATIO = 4;
  localparam logic [4:0] SIG = 5'h06;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_port = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] status;
  logic       irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  fmtmr_unit #(.CYC_PER_TICK(CPT), .SLOW_RATIO(RATIO), .SIGNATURE(SIG)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
    .host_wdata(host_wdata), .status(status), .irq(irq)
  );

  // behavioural reference model
  int       m_rs, m_div, m_rat, m_idx;
  int       m_pre [2];
  int       m_cnt [2];
  bit       m_run [2];
  bit       m_msk [2];
  bit       m_flg [2];

  always @(posedge clk or negedge rst_n) begin
    bit tk [2];
    bit ovf [2];
    bit ld [2];
    bit clr, upd;
    if (!rst_n) begin
      m_rs = 0; m_div = 0; m_rat = 0; m_idx = 0;
      for (int i = 0; i < 2; i++) begin
        m_pre[i] = 0; m_cnt[i] = 0; m_run[i] = 0; m_msk[i] = 0; m_flg[i] = 0;
      end
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      tk[0] = (m_div == CPT - 1);
      tk[1] = tk[0] && (m_rat == RATIO - 1);
      clr = host_wr && host_port && m_idx == 4 && host_wdata[7];
      upd = host_wr && host_port && m_idx == 4 && !host_wdata[7];
      for (int i = 0; i < 2; i++) begin
        ovf[i] = m_run[i] && tk[i] && m_cnt[i] == 255;
        ld[i]  = upd && host_wdata[i] && !m_run[i];
      end
      for (int i = 0; i < 2; i++) begin
        if (ld[i]) m_cnt[i] = m_pre[i];
        else if (m_run[i] && tk[i]) m_cnt[i] = (m_cnt[i] == 255) ? m_pre[i] : m_cnt[i] + 1;
        m_flg[i] = (m_flg[i] && !clr) || (ovf[i] && !m_msk[i]);
      end
      if (upd) begin
        m_run[0] = host_wdata[0]; m_run[1] = host_wdata[1];
        m_msk[0] = host_wdata[6]; m_msk[1] = host_wdata[5];
      end
      if (host_wr && host_port && m_idx == 2) m_pre[0] = host_wdata;
      if (host_wr && host_port && m_idx == 3) m_pre[1] = host_wdata;
      if (host_wr && !host_port) m_idx = host_wdata;
      if (tk[0]) m_rat = (m_rat == RATIO - 1) ? 0 : m_rat + 1;
      m_div = tk[0] ? 0 : m_div + 1;
    end
  end

  function automatic logic [7:0] model_status();
    return {m_flg[0] | m_flg[1], m_flg[0], m_flg[1], SIG};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model (R4 R6 R7 R9)
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R4 R6 R9 status vs model", status, model_status());
      check("R7 irq vs model", {7'd0, irq}, {7'd0, model_status()[7]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic port, input logic [7:0] d);
    host_wr = 1'b1; host_port = port; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_port = 1'b0; host_wdata = 8'h00;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    put(1'b0, idx);
    put(1'b1, d);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    wait_cyc(1);
    // R1 R9: reset state
    check("R1 reset status", status, 8'h06);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    wait_cyc(3);

    // R2: data write to unused index must not start anything
    wr_reg(8'h02, 8'hFF);
    wr_reg(8'h05, 8'h03);
    wait_cyc(3 * CPT);
    check("R2 unused index ignored", status, 8'h06);

    // R5 R6 R7: preload FF, fast started, slow masked
    wr_reg(8'h04, 8'h21);
    wait_cyc(CPT);
    check("R5 fast FF expiry", status, 8'hC6);
    check("R7 irq high", {7'd0, irq}, 8'h01);

    // R10 R3: stop, flag sticks
    wr_reg(8'h04, 8'h20);
    wait_cyc(2 * CPT);
    check("R10 flag kept after stop", status, 8'hC6);

    // R8: clear; R3: stopped timer stays quiet
    wr_reg(8'h04, 8'h80);
    check("R8 clear flags", status, 8'h06);
    wait_cyc(3 * CPT);
    check("R3 stopped no expiry", status, 8'h06);

    // R8: clear leaves the timer running
    wr_reg(8'h02, 8'hFC);
    wr_reg(8'h04, 8'h21);
    wait_cyc(5 * CPT);
    check("R4 preload FC expiry", status, 8'hC6);
    wr_reg(8'h04, 8'h80);
    wait_cyc(5 * CPT);
    check("R8 run kept after clear", status, 8'hC6);

    // R4 R3: period of 16 ticks on restart
    wr_reg(8'h04, 8'h20);
    wr_reg(8'h04, 8'h80);
    wr_reg(8'h02, 8'hF0);
    wr_reg(8'h04, 8'h21);
    wait_cyc(15 * CPT);
    check("R4 fast F0 not yet", status, 8'h06);
    wait_cyc(CPT);
    check("R4 fast F0 expired", status, 8'hC6);

    // R4 R6: slow timer, fast masked
    wr_reg(8'h04, 8'h00);
    wr_reg(8'h04, 8'h80);
    wr_reg(8'h03, 8'hFE);
    wr_reg(8'h04, 8'h42);
    wait_cyc(RATIO * CPT);
    check("R4 slow FE not yet", status, 8'h06);
    wait_cyc(RATIO * CPT);
    check("R6 slow flag", status, 8'hA6);
    check("R7 irq slow", {7'd0, irq}, 8'h01);

    // R6: masked fast timer never flags
    wr_reg(8'h04, 8'h00);
    wr_reg(8'h04, 8'h80);
    wr_reg(8'h02, 8'hFF);
    wr_reg(8'h04, 8'h41);
    wait_cyc(3 * CPT);
    check("R6 masked fast quiet", status, 8'h06);

    // R10: unmask, flag, then mask again
    wr_reg(8'h04, 8'h01);
    wait_cyc(CPT);
    check("R6 unmasked fast flag", status, 8'hC6);
    wr_reg(8'h04, 8'h41);
    wait_cyc(2 * CPT);
    check("R10 flag kept after mask", status, 8'hC6);

    wr_reg(8'h04, 8'h00);
    wr_reg(8'h04, 8'h80);
    check("R8 final clear", status, 8'h06);
    check("R9 signature", {3'b000, status[4:0]}, {3'b000, SIG});

    wait_cyc(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule